// File: doc/BRIEF.md
# Transmit Single-Bit Error Injector

This block sits on the transmit side of a bit-error-rate test generator. It takes the outgoing pattern stream beat by beat and inverts one chosen bit of one beat each time an error is requested. Test software or a test fixture uses it to check that a receiving checker counts exactly the errors it was sent.

An error is requested by a 0-to-1 edge on the selected trigger. A source-select control picks the trigger: a register trigger bit, or an external manual-insert pin. The edge is detected after the source multiplexer. Switching the select can therefore raise the selected trigger and request an error. A detected edge sets a pending flag. The flag is consumed by the first accepted beat that carries an insertion-opportunity mark. Several edges that come before that beat still yield a single error. A global enable gates everything and drops any pending request.

The stream uses valid/ready. It passes through combinationally and holds no storage. `s_ready` follows `m_ready` and `m_valid` follows `s_valid`. A beat transfers in the cycle where both valid and ready are high. A stalled beat is not counted as an opportunity, so a pending error waits for the next beat that transfers.

Top module: `tx_err_injector`

## Requirements
- R1: While `inj_enable` is 0, no beat is corrupted and `err_pulse` stays 0. A trigger edge seen while disabled produces no error after `inj_enable` returns to 1.
- R2: With `src_sel` = 0 only `reg_trig` can request an error. With `src_sel` = 1 only `ext_trig` can request one. Edges on the unselected trigger have no effect.
- R3: Each 0-to-1 edge of the selected trigger requests exactly one error. A trigger held high requests nothing more until it falls and rises again.
- R4: Any number of edges before the next opportunity beat produce a single error.
- R5: A change of `src_sel` that takes the selected trigger from 0 to 1 requests one error.
- R6: A pending error is applied to the first transferring beat with `s_opp` = 1 at least one cycle after the edge. That beat leaves with bit `ERR_BIT` of its data inverted. No other bit changes.
- R7: A trigger held high through reset requests exactly one error after reset is released.
- R8: `err_pulse` is high exactly in the cycles where a corrupted beat transfers.
- R9: Dropping `inj_enable` while an error is pending discards that error.
- R10: `m_valid` equals `s_valid` and `s_ready` equals `m_ready` in every cycle. A beat with no pending error passes unchanged in the same cycle.
- R11: An edge in the same cycle as a pending error is consumed is kept as a new request for a later opportunity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inj_enable | input | 1 | Enables single-error insertion |
| src_sel | input | 1 | Trigger source: 0 register bit, 1 external pin |
| reg_trig | input | 1 | Register trigger bit |
| ext_trig | input | 1 | External manual-insert trigger |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted (follows `m_ready`) |
| s_data | input | DATA_W | Input pattern data |
| s_opp | input | 1 | Beat is an insertion opportunity |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DATA_W | Output data, possibly with one bit inverted |
| err_pulse | output | 1 | High for the beat that carries an inserted error |

## Verification
A wrong pending flag or a wrong edge register shows up at the ports as a missing, extra or late inverted bit. A stuck-high flag corrupts the very next opportunity beat. A lost flag leaves the beat after an edge clean. The bench therefore predicts, beat by beat, which transfer must carry the inverted bit and compares both the data and the pulse. Collapse, discard, mode-switch, stall and reset cases each decide the outcome within one or two beats of the stimulus.

// File: rtl/txei_pkg.sv
package txei_pkg;
  typedef enum logic {
    SRC_REGISTER = 1'b0,
    SRC_EXTERNAL = 1'b1
  } trig_src_e;
endpackage

// File: rtl/txei_trig_edge.sv
module txei_trig_edge
  import txei_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic reg_trig,
  input  logic ext_trig,
  output logic rise
);
  trig_src_e src;
  logic      sel_trig;
  logic      prev_q;

  assign src      = trig_src_e'(src_sel);
  assign sel_trig = (src == SRC_EXTERNAL) ? ext_trig : reg_trig;

  // previous value resets low so a level held through reset counts once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel_trig;
  end

  assign rise = sel_trig & ~prev_q;

  AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3
endmodule

// File: rtl/txei_req_track.sv
module txei_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rise,
  input  logic opp_take,
  output logic fire
);
  logic pending_q;
  logic pending_d;

  assign fire = enable & pending_q & opp_take;

  always_comb begin
    pending_d = pending_q;
    if (fire)  pending_d = 1'b0;
    if (rise)  pending_d = 1'b1;
    if (!enable) pending_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= pending_d;
  end

  AST_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pending_q); // R9
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !fire); // R1
  AST_EDGE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rise) |=> pending_q); // R11
  AST_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rise) |=> !pending_q); // R4
endmodule

// File: rtl/txei_lane_flip.sv
module txei_lane_flip #(
  parameter int DATA_W  = 1,
  parameter int ERR_BIT = 0
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic              flip,
  output logic [DATA_W-1:0] out_data
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i == ERR_BIT) begin : g_hit
      assign out_data[i] = in_data[i] ^ flip;
    end else begin : g_pass
      assign out_data[i] = in_data[i];
    end
  end

  always_comb begin
    if (!flip) AST_CLEAN_PASS: assert (out_data == in_data); // R10
  end
endmodule

// File: rtl/tx_err_injector.sv
module tx_err_injector #(
  parameter int DATA_W  = 1,
  parameter int ERR_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inj_enable,
  input  logic              src_sel,
  input  logic              reg_trig,
  input  logic              ext_trig,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_opp,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              err_pulse
);
  logic rise;
  logic opp_take;
  logic fire;

  assign s_ready  = m_ready;
  assign m_valid  = s_valid;
  assign opp_take = s_valid & m_ready & s_opp;

  txei_trig_edge u_edge (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .reg_trig(reg_trig), .ext_trig(ext_trig), .rise(rise)
  );

  txei_req_track u_track (
    .clk(clk), .rst_n(rst_n), .enable(inj_enable),
    .rise(rise), .opp_take(opp_take), .fire(fire)
  );

  txei_lane_flip #(.DATA_W(DATA_W), .ERR_BIT(ERR_BIT)) u_flip (
    .in_data(s_data), .flip(fire), .out_data(m_data)
  );

  assign err_pulse = fire;

  AST_PULSE_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (m_valid && m_ready && s_opp)); // R8
  AST_PULSE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (m_data[ERR_BIT] != s_data[ERR_BIT])); // R6
  AST_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready == m_ready) && (m_valid == s_valid)); // R10
endmodule

// File: tb/tx_err_injector_tb.sv
module tx_err_injector_tb_top;
  localparam int PERIOD = 10;
  localparam int DW     = 1;

  typedef struct {
    logic [DW-1:0] data;
    logic          err;
    string         req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inj_enable = 1'b0, src_sel = 1'b0, reg_trig = 1'b0, ext_trig = 1'b0;
  logic          s_valid = 1'b0, s_opp = 1'b0, m_ready = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_ready, m_valid, err_pulse;
  logic [DW-1:0] m_data;

  item_t exp_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  always #(PERIOD/2) clk = ~clk;

  tx_err_injector #(.DATA_W(DW), .ERR_BIT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .inj_enable(inj_enable), .src_sel(src_sel),
    .reg_trig(reg_trig), .ext_trig(ext_trig), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_opp(s_opp), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .err_pulse(err_pulse)
  );

  // driver: apply one cycle of stimulus and queue what must come out
  task automatic step(input logic en, input logic md, input logic rt,
                      input logic et, input logic v, input logic rdy,
                      input logic op, input logic d, input logic flip,
                      input string req);
    item_t it;
    @(negedge clk);
    inj_enable = en; src_sel = md; reg_trig = rt; ext_trig = et;
    s_valid = v; m_ready = rdy; s_opp = op; s_data = d;
    if (v && rdy) begin
      it.data = d ^ flip;
      it.err  = flip;
      it.req  = req;
      exp_q.push_back(it);
    end
  endtask

  // monitor: sample a quarter period after the driver
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      n_cmp++;
      if (s_ready !== m_ready || m_valid !== s_valid) begin
        n_bad++;
        $display("FAIL R10 handshake: ready %b/%b valid %b/%b", s_ready, m_ready, m_valid, s_valid);
      end
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R10 unexpected beat: data %b err %b expected none", m_data, err_pulse);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          n_cmp++;
          if (m_data !== it.data || err_pulse !== it.err) begin
            n_bad++;
            $display("FAIL %s: data %b err %b expected data %b err %b",
                     it.req, m_data, err_pulse, it.data, it.err);
          end
        end
      end else begin
        n_cmp++;
        if (err_pulse !== 1'b0) begin
          n_bad++;
          $display("FAIL R8 pulse without transfer: err %b expected 0", err_pulse);
        end
      end
    end
  end

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state with trigger already high (R7)
    step(1,0,1,0, 1,1,1, 1'b1, 0, "R7 in reset");
    step(1,0,1,0, 1,1,1, 1'b0, 0, "R7 in reset");
    rst_n = 1'b1;
    step(1,0,1,0, 1,1,0, 1'b1, 0, "R7 edge after reset");
    step(1,0,1,0, 1,1,1, 1'b1, 1, "R7 single error");
    step(1,0,1,0, 1,1,1, 1'b0, 0, "R3 held level");
    step(1,0,1,0, 1,1,1, 1'b1, 0, "R3 held level");

    // register edge waits for an opportunity (R3, R6)
    step(1,0,0,0, 1,1,1, 1'b0, 0, "R3 low");
    step(1,0,1,0, 1,1,0, 1'b0, 0, "R6 edge no opp");
    step(1,0,1,0, 1,1,0, 1'b1, 0, "R6 still no opp");
    step(1,0,1,0, 1,1,1, 1'b0, 1, "R6 insert");
    step(1,0,1,0, 1,1,1, 1'b0, 0, "R3 one per edge");

    // collapse (R4)
    step(1,0,0,0, 1,1,0, 1'b1, 0, "R4");
    step(1,0,1,0, 1,1,0, 1'b1, 0, "R4");
    step(1,0,0,0, 1,1,0, 1'b1, 0, "R4");
    step(1,0,1,0, 1,1,0, 1'b0, 0, "R4");
    step(1,0,0,0, 1,1,0, 1'b0, 0, "R4");
    step(1,0,1,0, 1,1,0, 1'b1, 0, "R4");
    step(1,0,1,0, 1,1,1, 1'b1, 1, "R4 single error");
    step(1,0,1,0, 1,1,1, 1'b1, 0, "R4 no second error");

    // disabled (R1)
    step(0,0,0,0, 1,1,1, 1'b0, 0, "R1");
    step(0,0,1,0, 1,1,1, 1'b0, 0, "R1 edge while off");
    step(0,0,1,0, 1,1,1, 1'b1, 0, "R1 off");
    step(1,0,1,0, 1,1,1, 1'b1, 0, "R1 lost after enable");
    step(1,0,1,0, 1,1,1, 1'b0, 0, "R1 lost after enable");

    // discard (R9)
    step(1,0,0,0, 1,1,0, 1'b0, 0, "R9");
    step(1,0,1,0, 1,1,0, 1'b0, 0, "R9 arm");
    step(0,0,1,0, 1,1,0, 1'b1, 0, "R9 drop");
    step(1,0,1,0, 1,1,1, 1'b1, 0, "R9 discarded");
    step(1,0,1,0, 1,1,1, 1'b0, 0, "R9 discarded");

    // external source (R2)
    step(1,1,0,0, 1,1,1, 1'b0, 0, "R2");
    step(1,1,1,0, 1,1,1, 1'b1, 0, "R2 reg ignored");
    step(1,1,0,0, 1,1,1, 1'b0, 0, "R2 reg ignored");
    step(1,1,1,0, 1,1,1, 1'b1, 0, "R2 reg ignored");
    step(1,1,1,1, 1,1,0, 1'b0, 0, "R2 ext edge");
    step(1,1,1,1, 1,1,1, 1'b1, 1, "R2 ext insert");
    // mode 0 with ext edges ignored
    step(1,0,0,0, 1,1,1, 1'b1, 0, "R2");
    step(1,0,0,1, 1,1,1, 1'b1, 0, "R2 ext ignored");
    step(1,0,0,0, 1,1,1, 1'b0, 0, "R2 ext ignored");

    // mode switch fires (R5)
    step(1,1,1,0, 1,1,1, 1'b0, 0, "R5 setup");
    step(1,0,1,0, 1,1,0, 1'b0, 0, "R5 switch");
    step(1,0,1,0, 1,1,1, 1'b0, 1, "R5 insert");
    step(1,0,1,0, 1,1,1, 1'b0, 0, "R5 once");

    // stall and idle do not consume (R8, R6)
    step(1,0,0,0, 1,1,0, 1'b1, 0, "R8");
    step(1,0,1,0, 1,1,0, 1'b1, 0, "R8 arm");
    step(1,0,1,0, 1,0,1, 1'b1, 0, "R8 stalled");
    step(1,0,1,0, 0,1,1, 1'b1, 0, "R8 idle");
    step(1,0,1,0, 1,1,1, 1'b1, 1, "R8 insert on transfer");
    step(1,0,1,0, 1,1,1, 1'b1, 0, "R8 once");

    // edge in consume cycle is kept (R11)
    step(1,0,0,0, 1,1,0, 1'b0, 0, "R11");
    step(1,0,1,0, 1,1,0, 1'b0, 0, "R11 arm");
    step(1,0,0,0, 1,1,0, 1'b0, 0, "R11");
    step(1,0,1,0, 1,1,1, 1'b0, 1, "R11 consume with edge");
    step(1,0,1,0, 1,1,1, 1'b1, 1, "R11 second error");
    step(1,0,1,0, 1,1,1, 1'b1, 0, "R11 done");

    step(1,0,0,0, 0,1,0, 1'b0, 0, "end");
    step(1,0,0,0, 0,1,0, 1'b0, 0, "end");
    @(negedge clk);
    #(PERIOD/2);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 beats missing: %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule